// File: doc/BRIEF.md
# Random Number Generator Register Front End

This block is the software-visible face of a hardware random number generator. An external entropy source offers 128-bit random blocks, together with one-cycle alarm pulses from its health tests. The block holds one block at a time in four 32-bit data words and raises a ready flag. It does not accept another block until software writes 1 to the ready bit. Each accepted block is compared with the block accepted before it. An exact repeat is reported as a stuck-output alarm.

Alarm events are collected in a sticky status register whose bits are cleared by writing 1. A control register holds a global enable, a test-mode bit and one interrupt enable for each alarm. The interrupt output is high while any alarm bit that has its enable set is pending. A refill configuration register and an alarm-threshold register are stored here and driven out to the entropy source.

Top module: `trng_regfront`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `src_ready` is low.
- R2: When the enable is set, ready is low and `src_valid` is high, the block is captured at the clock edge and ready reads 1 after that edge. Data word k at byte offset 4*k returns bits [32k+31:32k] of the block.
- R3: While ready is 1, `src_ready` stays low and the source inputs do not change the data words.
- R4: The status register is at offset 0x10. Bit 0 is ready. Writing a 1 to bit 0 clears ready, and this allows the next block to be captured.
- R5: While the enable is 0, no block is captured and a low ready bit stays low. Register writes are still accepted.
- R6: A captured block equal to the previously captured block sets status bit 2 (stuck output). The first block after reset never sets it.
- R7: Alarm input bit j sets a status bit, and that bit stays set. The mapping is: `alarm_in[0]` to bit 1 (oscillator shutdown), `[1]` to bit 3 (noise), `[2]` to bit 4 (run), `[3]` to bit 5 (long run), `[4]` to bit 6 (poker), `[5]` to bit 7 (monobit).
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: The control register at 0x14 holds the enable in bit 10, test mode in bit 8 and the interrupt enables in bits 7:1. All other bits read 0. Bits 10 and 8 drive `rng_enable` and `test_mode`.
- R10: The register at 0x18 holds the maximum refill count in bits 31:16 and the minimum refill count in bits 7:0, and reads 0 in bits 15:8. The register at 0x1C holds the alarm threshold in bits 7:0. Each field drives its own output.
- R11: `irq` is the OR over status bits 7:1 of each bit ANDed with its control enable. Ready alone never raises it.
- R12: Reads of offsets not listed above, including offsets that are not word-aligned, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_valid | input | 1 | Entropy source offers a block |
| src_block | input | 128 | Offered random block |
| src_ready | output | 1 | The offered block is taken at this edge |
| alarm_in | input | 6 | One-cycle health-test alarm pulses |
| irq | output | 1 | Interrupt request |
| rng_enable | output | 1 | Global enable |
| test_mode | output | 1 | Test-mode control bit |
| refill_min | output | 8 | Minimum refill cycle count |
| refill_max | output | 16 | Maximum refill cycle count |
| alarm_thresh | output | 8 | Alarm threshold |

## Verification
The assertions assume that the entropy source obeys the `src_ready` handshake and that alarm pulses may arrive in any cycle, including a cycle in which software clears the same status bit. The random stimulus drives `src_valid` and `alarm_in` freely and keeps the enable set most of the time, so that captures, acknowledgements and clears interleave. About a quarter of the offered blocks repeat the held block, so that the stuck detector is exercised often.

// File: rtl/trng_regfront_pkg.sv
`timescale 1ns/1ps
package trng_regfront_pkg;
  localparam int WORD_W   = 32;
  localparam int OFS_STAT = 'h10;
  localparam int OFS_CTRL = 'h14;
  localparam int OFS_CFG  = 'h18;
  localparam int OFS_THR  = 'h1C;
  localparam int ST_READY = 0;
  localparam int ST_STUCK = 2;
  localparam int ALARM_W  = 6;

  // Alarm pulse vector to status bit positions 7:1 (bit 2 is internal).
  function automatic logic [7:1] alarm_to_status(input logic [ALARM_W-1:0] a);
    logic [7:1] v;
    v    = '0;
    v[1] = a[0];
    v[3] = a[1];
    v[4] = a[2];
    v[5] = a[3];
    v[6] = a[4];
    v[7] = a[5];
    return v;
  endfunction

  function automatic logic irq_calc(input logic [7:1] st, input logic [7:1] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/trng_out_hold.sv
`timescale 1ns/1ps
module trng_out_hold #(
  parameter int BLOCK_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               ack,
  input  logic               src_valid,
  input  logic [BLOCK_W-1:0] src_block,
  output logic               src_ready,
  output logic               ready_q,
  output logic [BLOCK_W-1:0] data_q,
  output logic               load_evt,
  output logic               stuck_evt
);
  logic have_prev_q;

  assign src_ready = enable && !ready_q;
  assign load_evt  = src_ready && src_valid;
  assign stuck_evt = load_evt && have_prev_q && (src_block == data_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      data_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (load_evt) begin
      ready_q     <= 1'b1;
      data_q      <= src_block;
      have_prev_q <= 1'b1;
    end else if (ack) begin
      ready_q     <= 1'b0;
    end
  end
endmodule

// File: rtl/trng_status_irq.sv
`timescale 1ns/1ps
module trng_status_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:1] set_vec,
  input  logic [7:1] clr_vec,
  input  logic [7:1] mask,
  output logic [7:1] status_q,
  output logic       irq
);
  import trng_regfront_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_vec;
  end

  assign irq = irq_calc(status_q, mask);
endmodule

// File: rtl/trng_cfg_regs.sv
`timescale 1ns/1ps
module trng_cfg_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_cfg,
  input  logic        wr_thr,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl_rd,
  output logic [31:0] cfg_rd,
  output logic [31:0] thr_rd,
  output logic        rng_enable,
  output logic        test_mode,
  output logic [7:1]  mask,
  output logic [7:0]  refill_min,
  output logic [15:0] refill_max,
  output logic [7:0]  alarm_thresh
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rng_enable   <= 1'b0;
      test_mode    <= 1'b0;
      mask         <= '0;
      refill_min   <= '0;
      refill_max   <= '0;
      alarm_thresh <= '0;
    end else begin
      if (wr_ctrl) begin
        rng_enable <= wdata[10];
        test_mode  <= wdata[8];
        mask       <= wdata[7:1];
      end
      if (wr_cfg) begin
        refill_max <= wdata[31:16];
        refill_min <= wdata[7:0];
      end
      if (wr_thr) alarm_thresh <= wdata[7:0];
    end
  end

  assign ctrl_rd = {21'b0, rng_enable, 1'b0, test_mode, mask, 1'b0};
  assign cfg_rd  = {refill_max, 8'h00, refill_min};
  assign thr_rd  = {24'h0, alarm_thresh};
endmodule

// File: rtl/trng_regfront.sv
`timescale 1ns/1ps
module trng_regfront #(
  parameter int ADDR_W     = 8,
  parameter int DATA_WORDS = 4
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          bus_wr,
  input  logic [ADDR_W-1:0]                             bus_addr,
  input  logic [31:0]                                   bus_wdata,
  output logic [31:0]                                   bus_rdata,
  input  logic                                          src_valid,
  input  logic [DATA_WORDS*trng_regfront_pkg::WORD_W-1:0] src_block,
  output logic                                          src_ready,
  input  logic [trng_regfront_pkg::ALARM_W-1:0]         alarm_in,
  output logic                                          irq,
  output logic                                          rng_enable,
  output logic                                          test_mode,
  output logic [7:0]                                    refill_min,
  output logic [15:0]                                   refill_max,
  output logic [7:0]                                    alarm_thresh
);
  import trng_regfront_pkg::*;

  localparam int BLOCK_W = DATA_WORDS * WORD_W;

  logic               hit_stat, hit_ctrl, hit_cfg, hit_thr;
  logic               ack_rdy;
  logic [7:1]         clr_bits, set_bits, status_bits, mask_bits;
  logic               ready_q, load_evt, stuck_evt;
  logic [BLOCK_W-1:0] data_q;
  logic [31:0]        ctrl_rd, cfg_rd, thr_rd;
  logic [DATA_WORDS-1:0] word_hit;
  logic [31:0]        word_val [DATA_WORDS];

  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
  assign hit_thr  = (bus_addr == ADDR_W'(OFS_THR));

  assign ack_rdy  = bus_wr && hit_stat && bus_wdata[ST_READY];
  assign clr_bits = (bus_wr && hit_stat) ? bus_wdata[7:1] : '0;

  always_comb begin
    set_bits           = alarm_to_status(alarm_in);
    set_bits[ST_STUCK] = stuck_evt;
  end

  trng_out_hold #(.BLOCK_W(BLOCK_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .enable(rng_enable), .ack(ack_rdy),
    .src_valid(src_valid), .src_block(src_block), .src_ready(src_ready),
    .ready_q(ready_q), .data_q(data_q), .load_evt(load_evt),
    .stuck_evt(stuck_evt)
  );

  trng_status_irq u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_bits), .clr_vec(clr_bits),
    .mask(mask_bits), .status_q(status_bits), .irq(irq)
  );

  trng_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(bus_wr && hit_ctrl), .wr_cfg(bus_wr && hit_cfg),
    .wr_thr(bus_wr && hit_thr), .wdata(bus_wdata),
    .ctrl_rd(ctrl_rd), .cfg_rd(cfg_rd), .thr_rd(thr_rd),
    .rng_enable(rng_enable), .test_mode(test_mode), .mask(mask_bits),
    .refill_min(refill_min), .refill_max(refill_max),
    .alarm_thresh(alarm_thresh)
  );

  for (genvar g = 0; g < DATA_WORDS; g++) begin : g_word
    assign word_hit[g] = (bus_addr == ADDR_W'(g * 4));
    assign word_val[g] = data_q[g*WORD_W +: WORD_W];
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < DATA_WORDS; i++)
      if (word_hit[i]) bus_rdata = word_val[i];
    if (hit_stat) bus_rdata = {24'h0, status_bits, ready_q};
    if (hit_ctrl) bus_rdata = ctrl_rd;
    if (hit_cfg)  bus_rdata = cfg_rd;
    if (hit_thr)  bus_rdata = thr_rd;
  end
endmodule

// File: rtl/trng_regfront_chk.sv
`timescale 1ns/1ps
module trng_regfront_chk #(
  parameter int BLOCK_W = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ready_q,
  input logic [BLOCK_W-1:0] data_q,
  input logic               ack_rdy,
  input logic [7:1]         status_bits,
  input logic [7:1]         clr_bits,
  input logic               stuck_evt,
  input logic               src_ready,
  input logic               rng_enable,
  input logic               irq
);
  a_r3_hold_block: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !ack_rdy) |=> (ready_q && $stable(data_q)));

  a_r2_accept_gate: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (rng_enable && !ready_q));

  a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rng_enable && !ready_q) |=> !ready_q);

  a_r6_stuck_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_evt |=> status_bits[2]);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_bits & $past(status_bits & ~clr_bits))
              == $past(status_bits & ~clr_bits)));

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_bits == '0) |-> !irq);
endmodule

bind trng_regfront trng_regfront_chk #(.BLOCK_W(BLOCK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_q(ready_q), .data_q(data_q),
  .ack_rdy(ack_rdy), .status_bits(status_bits), .clr_bits(clr_bits),
  .stuck_evt(stuck_evt), .src_ready(src_ready), .rng_enable(rng_enable),
  .irq(irq)
);

// File: tb/trng_regfront_bench.sv
`timescale 1ns/1ps
module trng_regfront_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         src_valid = 1'b0;
  logic [127:0] src_block = '0;
  logic         src_ready;
  logic [5:0]   alarm_in = '0;
  logic         irq, rng_enable, test_mode;
  logic [7:0]   refill_min, alarm_thresh;
  logic [15:0]  refill_max;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic         m_ready, m_have;
  logic [127:0] m_data;
  logic [7:0]   m_st;
  logic [31:0]  m_ctrl, m_cfg, m_thr;

  trng_regfront u_trng_regfront (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_valid(src_valid),
    .src_block(src_block), .src_ready(src_ready), .alarm_in(alarm_in),
    .irq(irq), .rng_enable(rng_enable), .test_mode(test_mode),
    .refill_min(refill_min), .refill_max(refill_max),
    .alarm_thresh(alarm_thresh)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] b_alarm(input logic [5:0] a);
    logic [7:0] v = 8'h00;
    v[1] = a[0]; v[3] = a[1]; v[4] = a[2];
    v[5] = a[3]; v[6] = a[4]; v[7] = a[5];
    return v;
  endfunction

  function automatic logic [31:0] b_read(input logic [7:0] a);
    case (a)
      8'h00: return m_data[31:0];
      8'h04: return m_data[63:32];
      8'h08: return m_data[95:64];
      8'h0C: return m_data[127:96];
      8'h10: return {24'h0, m_st[7:1], m_ready};
      8'h14: return m_ctrl;
      8'h18: return m_cfg;
      8'h1C: return m_thr;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    if (a < 8'h10 && a[1:0] == 2'b00) return "R2 R3 data word";
    case (a)
      8'h10: return "R4 R6 R7 R8 status";
      8'h14: return "R9 control";
      8'h18, 8'h1C: return "R10 config";
      default: return "R12 unmapped";
    endcase
  endfunction

  task automatic check_all();
    logic en = m_ctrl[10];
    chk(req_of(bus_addr), bus_rdata, b_read(bus_addr));
    chk("R11 irq", {31'b0, irq}, {31'b0, |(m_st[7:1] & m_ctrl[7:1])});
    chk("R2 R5 src_ready", {31'b0, src_ready}, {31'b0, en && !m_ready});
    chk("R9 enable/test outputs", {30'b0, rng_enable, test_mode}, {30'b0, m_ctrl[10], m_ctrl[8]});
    chk("R10 refill/threshold outputs", {refill_max, refill_min, alarm_thresh},
        {m_cfg[31:16], m_cfg[7:0], m_thr[7:0]});
  endtask

  task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                     input logic sv, input logic [127:0] blk, input logic [5:0] al);
    logic ld, stk;
    logic [7:0] clr;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    src_valid = sv; src_block = blk; alarm_in = al;
    ld  = m_ctrl[10] && !m_ready && sv;
    stk = ld && m_have && (blk == m_data);
    clr = (wr && a == 8'h10) ? {wd[7:1], 1'b0} : 8'h00;
    @(posedge clk);
    if (ld) begin m_ready = 1'b1; m_data = blk; m_have = 1'b1; end
    else if (wr && a == 8'h10 && wd[0]) m_ready = 1'b0;
    m_st = (m_st & ~clr) | b_alarm(al) | {5'b0, stk, 2'b0};
    if (wr && a == 8'h14) m_ctrl = wd & 32'h0000_05FE;
    if (wr && a == 8'h18) m_cfg  = wd & 32'hFFFF_00FF;
    if (wr && a == 8'h1C) m_thr  = wd & 32'h0000_00FF;
    #1;
    check_all();
  endtask

  function automatic logic [7:0] pick_addr();
    case ($urandom % 12)
      0: return 8'h00; 1: return 8'h04; 2: return 8'h08; 3: return 8'h0C;
      4, 5: return 8'h10; 6: return 8'h14; 7: return 8'h18; 8: return 8'h1C;
      9: return 8'h20; 10: return 8'h13;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] b1, b2;
    void'($urandom(32'h5EED_0042));
    m_ready = 0; m_have = 0; m_data = '0; m_st = '0;
    m_ctrl = '0; m_cfg = '0; m_thr = '0;
    b1 = {$urandom, $urandom, $urandom, $urandom};
    b2 = {$urandom, $urandom, $urandom, $urandom};

    // R1: reset state, with source offering data during reset
    repeat (3) @(posedge clk);
    src_valid = 1'b1; src_block = b1;
    foreach (b1[i]) begin end
    for (int a = 0; a < 32; a += 4) begin
      bus_addr = 8'(a); #1;
      chk("R1 reset register value", bus_rdata, 32'h0);
    end
    chk("R1 reset irq/src_ready", {30'b0, irq, src_ready}, 32'h0);
    @(negedge clk); rst_n = 1'b1; src_valid = 1'b0;

    // R5: disabled, offered block not taken
    cyc(0, 8'h10, 0, 1, b1, 0);
    chk("R5 ready stays low when disabled", bus_rdata, 32'h0);
    // R9: enable with all interrupt enables
    cyc(1, 8'h14, 32'hFFFF_FFFF, 0, b1, 0);
    // R2: capture
    cyc(0, 8'h00, 0, 1, b1, 0);
    chk("R2 word0 after capture", bus_rdata, b1[31:0]);
    // R3: new offers ignored while ready
    cyc(0, 8'h04, 0, 1, b2, 0);
    cyc(0, 8'h08, 0, 1, b2, 0);
    cyc(0, 8'h0C, 0, 1, b2, 0);
    chk("R3 word3 still first block", bus_rdata, b1[127:96]);
    cyc(0, 8'h10, 0, 0, b2, 0);
    chk("R11 ready alone keeps irq low", {31'b0, irq}, 32'h0);
    // R4: acknowledge, then same block again -> R6 stuck
    cyc(1, 8'h10, 32'h1, 0, b1, 0);
    cyc(0, 8'h10, 0, 1, b1, 0);
    chk("R6 stuck bit on repeat", bus_rdata, 32'h5);
    chk("R11 irq on enabled stuck", {31'b0, irq}, 32'h1);
    // R8: clear with simultaneous alarm: set wins
    cyc(1, 8'h10, 32'hFF, 0, b1, 6'h3F);
    chk("R7 R8 set wins over clear", bus_rdata, 32'hFA);
    cyc(1, 8'h10, 32'h0, 0, b1, 0);
    chk("R8 write zero keeps bits", bus_rdata, 32'hFA);
    cyc(1, 8'h10, 32'hFE, 0, b1, 0);
    chk("R8 write one clears bits", bus_rdata, 32'h0);
    // R11: masked alarm leaves irq low
    cyc(1, 8'h14, 32'h0000_0500, 0, b1, 6'h01);
    cyc(0, 8'h14, 0, 0, b1, 0);
    chk("R11 masked alarm no irq", {31'b0, irq}, 32'h0);
    chk("R9 control readback", bus_rdata, 32'h0000_0500);
    // R10
    cyc(1, 8'h18, 32'hFFFF_FFFF, 0, b1, 0);
    chk("R10 config readback", bus_rdata, 32'hFFFF_00FF);
    cyc(1, 8'h1C, 32'hABCD_1234, 0, b1, 0);
    chk("R10 threshold readback", bus_rdata, 32'h34);
    // R12
    cyc(0, 8'h20, 0, 0, b1, 0);
    chk("R12 offset 0x20", bus_rdata, 32'h0);
    cyc(0, 8'h11, 0, 0, b1, 0);
    chk("R12 misaligned", bus_rdata, 32'h0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic wr = ($urandom % 4 == 0);
      logic [7:0] a = pick_addr();
      logic [31:0] wd = $urandom;
      logic [127:0] blk;
      if (a == 8'h14) wd[10] = ($urandom % 4 != 0);
      if (a == 8'h10 && ($urandom % 2 == 0)) wd[0] = 1'b1;
      blk = ($urandom % 4 == 0) ? m_data : {$urandom, $urandom, $urandom, $urandom};
      cyc(wr, a, wd, ($urandom % 2 == 0), blk,
          ($urandom % 8 == 0) ? 6'($urandom) : 6'h0);
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule